// File: doc/BRIEF.md
# Accumulator ALU with Program-Status Flags

This block is the arithmetic and logic engine of an 8-bit accumulator machine. Each clock it takes the accumulator, a second operand byte, the B register, the incoming carry and auxiliary-carry bits and an operation code. It produces the new accumulator, the new B register and the new operand byte where an operation writes them. It also produces new carry (C), auxiliary carry (AC) and overflow (OV) values, with a write enable per flag so that the surrounding status register changes only the flags the operation owns.

The operations are add, add with carry, subtract with borrow, increment, decrement, multiply, divide and decimal adjust. There are also the bitwise AND, OR and XOR, complement, clear, plain and through-carry rotates in both directions, a nibble swap of the accumulator and a low-nibble exchange between the accumulator and the operand. Fetching the operands is left to the caller. All results are registered, so each one appears exactly one clock after its inputs.

Top module: `alu8_core`

## Requirements
- R1: ADD (code 0) returns A+X. ADDC (code 1) returns A+X+C. Both write C, AC and OV. C is the carry out of bit 7 and AC is the carry out of bit 3. OV is set when exactly one of the carries out of bits 6 and 7 occurs. For example, 3Fh+D3h with C=0 gives 12h with C=1, AC=1 and OV=0.
- R2: SUBB (code 2) returns A−X−C. It writes C (borrow out of bit 7), AC (borrow out of bit 3) and OV (signed overflow). There is no subtract that ignores C.
- R3: INC (code 3) and DEC (code 4) return A+1 and A−1 modulo 256. They raise no flag write enable.
- R4: MUL (code 5) forms the 16-bit product A×B. The low byte goes to A and the high byte goes to B, with B written. C is written as 0, and OV is written as 1 exactly when the product exceeds FFh. FFh×FFh gives A=01h, B=FEh.
- R5: DIV (code 6) writes A=A/B and B=A mod B. C is written as 0, and OV is written as 0. When B=0, OV is written as 1 and the A and B results are unspecified.
- R6: DA (code 7) adds 06h when A[3:0]>9 or AC=1. It then adds 60h when the upper nibble of that sum is >9 or C=1 or the first addition carried. Only C is written: it is the incoming C ORed with any carry of the correction. 4Ch with C=0 and AC=0 gives 52h.
- R7: AND (8), OR (9), XOR (10), CPL (11, returns ~A) and CLR (12, returns 00h) raise no flag write enable.
- R8: RL (13) and RR (14) rotate A by one place and raise no flag write enable. RLC (15) and RRC (16) rotate the 9-bit value {C,A} and write only C, which receives the bit shifted out of A.
- R9: SWAP (17) exchanges the nibbles of A. XCHD (18) exchanges bits 3..0 of A and the operand, returning the new operand and writing it. Bits 7..4 of both stay unchanged, and no flag is written.
- R10: Every output is registered, with one clock of latency. Synchronous reset drives all outputs and enables to 0. When a flag, B or the operand is not written, its output repeats the input value (cy_i, ac_i, breg_i, opnd_i), and OV repeats 0. Codes 19 to 31 return A unchanged and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code (see requirements) |
| acc_i | input | 8 | Accumulator |
| opnd_i | input | 8 | Second operand byte |
| breg_i | input | 8 | B register |
| cy_i | input | 1 | Incoming carry flag |
| ac_i | input | 1 | Incoming auxiliary-carry flag |
| acc_o | output | 8 | New accumulator |
| breg_o | output | 8 | New B register |
| breg_we_o | output | 1 | B register write enable |
| opnd_o | output | 8 | New operand byte |
| opnd_we_o | output | 1 | Operand write enable |
| cy_o | output | 1 | New carry flag |
| cy_we_o | output | 1 | Carry write enable |
| ac_o | output | 1 | New auxiliary-carry flag |
| ac_we_o | output | 1 | Auxiliary-carry write enable |
| ov_o | output | 1 | New overflow flag |
| ov_we_o | output | 1 | Overflow write enable |

## Verification
Every result, including those of multiply, divide and decimal adjust, lands exactly one clock after its operation is presented. There is no multi-cycle path. The bench drives a new operation on each falling edge and compares all outputs at the next falling edge against the model's prediction for that operation, so every clock is both a stimulus and a check. The checker uses the same one-cycle relation: it compares outputs to the previous cycle's inputs through $past, and it skips the first cycle after reset.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DW  = 8;
    localparam int NIB = DW / 2;
    localparam int OPW = 5;
    localparam logic [NIB-1:0] NIB_MAX = NIB'(9);

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 5'd0,  OP_ADDC = 5'd1,  OP_SUBB = 5'd2,  OP_INC  = 5'd3,
        OP_DEC  = 5'd4,  OP_MUL  = 5'd5,  OP_DIV  = 5'd6,  OP_DA   = 5'd7,
        OP_AND  = 5'd8,  OP_OR   = 5'd9,  OP_XOR  = 5'd10, OP_CPL  = 5'd11,
        OP_CLR  = 5'd12, OP_RL   = 5'd13, OP_RR   = 5'd14, OP_RLC  = 5'd15,
        OP_RRC  = 5'd16, OP_SWAP = 5'd17, OP_XCHD = 5'd18
    } alu_op_e;

    typedef struct packed {
        logic [DW-1:0] acc;
        logic [DW-1:0] breg;
        logic          breg_we;
        logic [DW-1:0] opnd;
        logic          opnd_we;
        logic          cy;
        logic          cy_we;
        logic          ac;
        logic          ac_we;
        logic          ov;
        logic          ov_we;
    } alu_res_t;

    function automatic logic is_arith(alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUBB);
    endfunction
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] x,
    input  logic          cin,
    output logic [DW-1:0] sum,
    output logic          cy,
    output logic          ac,
    output logic          ov
);
    logic [DW-1:0]  xx;
    logic           ci;
    logic           sub;
    logic [NIB:0]   lo;
    logic [DW-1:0]  mid;
    logic [DW:0]    full;

    always_comb begin
        xx  = x;
        ci  = 1'b0;
        sub = 1'b0;
        unique case (op)
            OP_ADDC: ci = cin;
            OP_SUBB: begin xx = ~x; ci = ~cin; sub = 1'b1; end
            OP_INC:  begin xx = '0; ci = 1'b1; end
            OP_DEC:  begin xx = '1; ci = 1'b0; end
            default: ;
        endcase
        lo   = {1'b0, a[NIB-1:0]} + {1'b0, xx[NIB-1:0]} + (NIB+1)'(ci);
        mid  = {1'b0, a[DW-2:0]}  + {1'b0, xx[DW-2:0]}  + DW'(ci);
        full = {1'b0, a}          + {1'b0, xx}          + (DW+1)'(ci);
        sum  = full[DW-1:0];
        cy   = full[DW] ^ sub;
        ac   = lo[NIB] ^ sub;
        ov   = full[DW] ^ mid[DW-1];
    end
endmodule

// File: rtl/alu8_muldiv.sv
module alu8_muldiv
    import alu8_pkg::*;
(
    input  logic          is_div,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] lo_q,
    output logic [DW-1:0] hi_r,
    output logic          ov
);
    logic [2*DW-1:0] prod;
    logic            bzero;

    always_comb begin
        prod  = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};
        bzero = (b == '0);
        if (is_div) begin
            lo_q = bzero ? a : a / b;
            hi_r = bzero ? b : a % b;
            ov   = bzero;
        end else begin
            lo_q = prod[DW-1:0];
            hi_r = prod[2*DW-1:DW];
            ov   = |prod[2*DW-1:DW];
        end
    end
endmodule

// File: rtl/alu8_bcd.sv
module alu8_bcd
    import alu8_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic          cin,
    input  logic          acin,
    output logic [DW-1:0] res,
    output logic          cy
);
    localparam logic [DW:0] LO_FIX = (DW+1)'(6);
    localparam logic [DW:0] HI_FIX = (DW+1)'(6) << NIB;

    logic [DW:0] t1;
    logic [DW:0] t2;

    always_comb begin
        t1 = {1'b0, a};
        if ((a[NIB-1:0] > NIB_MAX) || acin)
            t1 = t1 + LO_FIX;
        t2 = {1'b0, t1[DW-1:0]};
        if ((t1[DW-1:NIB] > NIB_MAX) || cin || t1[DW])
            t2 = t2 + HI_FIX;
        res = t2[DW-1:0];
        cy  = cin | t1[DW] | t2[DW];
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
(
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] x,
    input  logic          cin,
    output logic [DW-1:0] res,
    output logic [DW-1:0] xout,
    output logic          cy
);
    always_comb begin
        res  = a;
        xout = x;
        cy   = cin;
        unique case (op)
            OP_AND:  res = a & x;
            OP_OR:   res = a | x;
            OP_XOR:  res = a ^ x;
            OP_CPL:  res = ~a;
            OP_CLR:  res = '0;
            OP_RL:   res = {a[DW-2:0], a[DW-1]};
            OP_RR:   res = {a[0], a[DW-1:1]};
            OP_RLC:  begin res = {a[DW-2:0], cin}; cy = a[DW-1]; end
            OP_RRC:  begin res = {cin, a[DW-1:1]}; cy = a[0]; end
            OP_SWAP: res = {a[NIB-1:0], a[DW-1:NIB]};
            OP_XCHD: begin
                res  = {a[DW-1:NIB], x[NIB-1:0]};
                xout = {x[DW-1:NIB], a[NIB-1:0]};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [4:0]    op_i,
    input  logic [7:0]    acc_i,
    input  logic [7:0]    opnd_i,
    input  logic [7:0]    breg_i,
    input  logic          cy_i,
    input  logic          ac_i,
    output logic [7:0]    acc_o,
    output logic [7:0]    breg_o,
    output logic          breg_we_o,
    output logic [7:0]    opnd_o,
    output logic          opnd_we_o,
    output logic          cy_o,
    output logic          cy_we_o,
    output logic          ac_o,
    output logic          ac_we_o,
    output logic          ov_o,
    output logic          ov_we_o
);
    alu_op_e       op;
    logic [DW-1:0] as_sum, md_lo, md_hi, da_res, lg_res, lg_x;
    logic          as_cy, as_ac, as_ov, md_ov, da_cy, lg_cy;
    alu_res_t      nxt, cur;

    assign op = alu_op_e'(op_i);

    alu8_addsub u_addsub (
        .op(op), .a(acc_i), .x(opnd_i), .cin(cy_i),
        .sum(as_sum), .cy(as_cy), .ac(as_ac), .ov(as_ov)
    );

    alu8_muldiv u_muldiv (
        .is_div(op == OP_DIV), .a(acc_i), .b(breg_i),
        .lo_q(md_lo), .hi_r(md_hi), .ov(md_ov)
    );

    alu8_bcd u_bcd (
        .a(acc_i), .cin(cy_i), .acin(ac_i), .res(da_res), .cy(da_cy)
    );

    alu8_logic u_logic (
        .op(op), .a(acc_i), .x(opnd_i), .cin(cy_i),
        .res(lg_res), .xout(lg_x), .cy(lg_cy)
    );

    always_comb begin
        nxt         = '0;
        nxt.acc     = acc_i;
        nxt.breg    = breg_i;
        nxt.opnd    = opnd_i;
        nxt.cy      = cy_i;
        nxt.ac      = ac_i;
        case (op)
            OP_ADD, OP_ADDC, OP_SUBB, OP_INC, OP_DEC: begin
                nxt.acc = as_sum;
                if (is_arith(op)) begin
                    nxt.cy = as_cy; nxt.ac = as_ac; nxt.ov = as_ov;
                    nxt.cy_we = 1'b1; nxt.ac_we = 1'b1; nxt.ov_we = 1'b1;
                end
            end
            OP_MUL, OP_DIV: begin
                nxt.acc     = md_lo;
                nxt.breg    = md_hi;
                nxt.breg_we = 1'b1;
                nxt.cy      = 1'b0;
                nxt.cy_we   = 1'b1;
                nxt.ov      = md_ov;
                nxt.ov_we   = 1'b1;
            end
            OP_DA: begin
                nxt.acc   = da_res;
                nxt.cy    = da_cy;
                nxt.cy_we = 1'b1;
            end
            OP_AND, OP_OR, OP_XOR, OP_CPL, OP_CLR, OP_RL, OP_RR,
            OP_RLC, OP_RRC, OP_SWAP, OP_XCHD: begin
                nxt.acc     = lg_res;
                nxt.opnd    = lg_x;
                nxt.opnd_we = (op == OP_XCHD);
                nxt.cy      = lg_cy;
                nxt.cy_we   = (op == OP_RLC) || (op == OP_RRC);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign acc_o     = cur.acc;
    assign breg_o    = cur.breg;
    assign breg_we_o = cur.breg_we;
    assign opnd_o    = cur.opnd;
    assign opnd_we_o = cur.opnd_we;
    assign cy_o      = cur.cy;
    assign cy_we_o   = cur.cy_we;
    assign ac_o      = cur.ac;
    assign ac_we_o   = cur.ac_we;
    assign ov_o      = cur.ov;
    assign ov_we_o   = cur.ov_we;
endmodule

// File: rtl/alu8_check.sv
module alu8_check
    import alu8_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [4:0] op_i,
    input logic [7:0] acc_i,
    input logic [7:0] opnd_i,
    input logic [7:0] breg_i,
    input logic       cy_i,
    input logic       ac_i,
    input logic [7:0] acc_o,
    input logic [7:0] breg_o,
    input logic       breg_we_o,
    input logic [7:0] opnd_o,
    input logic       opnd_we_o,
    input logic       cy_o,
    input logic       cy_we_o,
    input logic       ac_o,
    input logic       ac_we_o,
    input logic       ov_o,
    input logic       ov_we_o
);
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    assert_incdec_keeps_carry_R3: assert property (@(posedge clk) disable iff (rst)
        (armed && ($past(op_i) == 5'd3 || $past(op_i) == 5'd4)) |-> !cy_we_o);

    assert_mul_flags_R4: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(op_i) == 5'd5) |-> (breg_we_o && !cy_o && ov_o == (breg_o != 8'h00)));

    assert_div_flags_R5: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(op_i) == 5'd6) |-> (cy_we_o && !cy_o && ov_o == ($past(breg_i) == 8'h00)));

    assert_logic_no_flags_R7: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(op_i) >= 5'd8 && $past(op_i) <= 5'd12)
        |-> !(cy_we_o || ac_we_o || ov_we_o));

    assert_rotc_only_carry_R8: assert property (@(posedge clk) disable iff (rst)
        (armed && ($past(op_i) == 5'd15 || $past(op_i) == 5'd16))
        |-> (cy_we_o && !ac_we_o && !ov_we_o));

    assert_xchd_high_kept_R9: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(op_i) == 5'd18)
        |-> (opnd_we_o && acc_o[7:4] == $past(acc_i[7:4]) && opnd_o[7:4] == $past(opnd_i[7:4])));

    assert_reset_clear_R10: assert property (@(posedge clk)
        $past(rst) |-> (acc_o == 8'h00 && !breg_we_o && !opnd_we_o && !cy_we_o && !ac_we_o && !ov_we_o));
endmodule

bind alu8_core alu8_check u_chk (.*);

// File: tb/alu8_core_bench.sv
module alu8_core_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic [4:0] op_i;
    logic [7:0] acc_i, opnd_i, breg_i;
    logic       cy_i, ac_i;
    logic [7:0] acc_o, breg_o, opnd_o;
    logic       breg_we_o, opnd_we_o, cy_o, cy_we_o, ac_o, ac_we_o, ov_o, ov_we_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    alu8_core u_alu8_core (.*);

    // expected values
    int e_acc, e_b, e_bwe, e_x, e_xwe, e_cy, e_cwe, e_ac, e_acwe, e_ov, e_ovwe;
    bit skip_ab;

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic int sgn(int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    task automatic model(int op, int a, int x, int b, int c, int h);
        int s, lo, sv;
        e_acc = a; e_b = b; e_bwe = 0; e_x = x; e_xwe = 0;
        e_cy = c; e_cwe = 0; e_ac = h; e_acwe = 0; e_ov = 0; e_ovwe = 0;
        skip_ab = 0;
        case (op)
            0, 1: begin
                s  = a + x + ((op == 1) ? c : 0);
                lo = (a % 16) + (x % 16) + ((op == 1) ? c : 0);
                sv = sgn(a) + sgn(x) + ((op == 1) ? c : 0);
                e_acc = s % 256; e_cy = (s > 255); e_ac = (lo > 15);
                e_ov = (sv > 127 || sv < -128);
                e_cwe = 1; e_acwe = 1; e_ovwe = 1;
            end
            2: begin
                s  = a - x - c;
                lo = (a % 16) - (x % 16) - c;
                sv = sgn(a) - sgn(x) - c;
                e_acc = (s + 512) % 256; e_cy = (s < 0); e_ac = (lo < 0);
                e_ov = (sv > 127 || sv < -128);
                e_cwe = 1; e_acwe = 1; e_ovwe = 1;
            end
            3: e_acc = (a + 1) % 256;
            4: e_acc = (a + 255) % 256;
            5: begin
                s = a * b; e_acc = s % 256; e_b = s / 256; e_bwe = 1;
                e_cy = 0; e_cwe = 1; e_ov = (s > 255); e_ovwe = 1;
            end
            6: begin
                e_bwe = 1; e_cy = 0; e_cwe = 1; e_ovwe = 1;
                if (b == 0) begin e_ov = 1; skip_ab = 1; end
                else begin e_acc = a / b; e_b = a % b; end
            end
            7: begin
                s = a;
                if ((a % 16) > 9 || h) s = s + 6;
                e_cy = c | (s > 255);
                s = s % 256;
                if ((s / 16) > 9 || e_cy) begin
                    s = s + 96;
                    if (s > 255) e_cy = 1;
                end
                e_acc = s % 256; e_cwe = 1;
            end
            8:  e_acc = a & x;
            9:  e_acc = a | x;
            10: e_acc = a ^ x;
            11: e_acc = 255 - a;
            12: e_acc = 0;
            13: e_acc = ((a * 2) % 256) + (a / 128);
            14: e_acc = (a / 2) + (a % 2) * 128;
            15: begin e_acc = ((a * 2) % 256) + c; e_cy = a / 128; e_cwe = 1; end
            16: begin e_acc = (a / 2) + c * 128; e_cy = a % 2; e_cwe = 1; end
            17: e_acc = (a % 16) * 16 + a / 16;
            18: begin
                e_acc = (a / 16) * 16 + (x % 16);
                e_x = (x / 16) * 16 + (a % 16); e_xwe = 1;
            end
            default: ;
        endcase
    endtask

    function automatic string rtag(int op);
        case (op)
            0, 1:  return "R1";
            2:     return "R2";
            3, 4:  return "R3";
            5:     return "R4";
            6:     return "R5";
            7:     return "R6";
            8, 9, 10, 11, 12: return "R7";
            13, 14, 15, 16:   return "R8";
            17, 18: return "R9";
            default: return "R10";
        endcase
    endfunction

    // drive on falling edge, compare one clock later on next falling edge
    task automatic run(int op, int a, int x, int b, int c, int h);
        string t;
        op_i = 5'(op); acc_i = 8'(a); opnd_i = 8'(x); breg_i = 8'(b);
        cy_i = 1'(c); ac_i = 1'(h);
        model(op, a, x, b, c, h);
        t = rtag(op);
        @(negedge clk);
        if (!skip_ab) begin
            chk({t, " acc"}, acc_o, e_acc);
            chk({t, " breg"}, breg_o, e_b);
        end
        chk({t, " breg_we"}, breg_we_o, e_bwe);
        chk({t, " opnd"}, opnd_o, e_x);
        chk({t, " opnd_we"}, opnd_we_o, e_xwe);
        chk({t, " cy"}, cy_o, e_cy);
        chk({t, " cy_we"}, cy_we_o, e_cwe);
        chk({t, " ac"}, ac_o, e_ac);
        chk({t, " ac_we"}, ac_we_o, e_acwe);
        chk({t, " ov"}, ov_o, e_ov);
        chk({t, " ov_we"}, ov_we_o, e_ovwe);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; op_i = 5'd5; acc_i = 8'hFF; opnd_i = 8'hAA; breg_i = 8'hFF;
        cy_i = 1'b1; ac_i = 1'b1;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 reset acc", acc_o, 0);
        chk("R10 reset we", {breg_we_o, opnd_we_o, cy_we_o, ac_we_o, ov_we_o}, 0);
        rst = 1'b0;

        run(0, 8'h3F, 8'hD3, 0, 0, 0);      // R1 spec case: 12h C=1 AC=1 OV=0
        run(1, 8'h7F, 8'h00, 0, 1, 0);      // R1 ADDC carry into sign, OV
        run(0, 8'h80, 8'h80, 0, 0, 0);      // R1 C=1 OV=1
        run(2, 8'h10, 8'h4F, 0, 1, 0);      // R2 borrow
        run(2, 8'h80, 8'h01, 0, 0, 0);      // R2 signed overflow
        run(3, 8'hFF, 0, 0, 1, 0);          // R3 wrap, carry untouched
        run(4, 8'h00, 0, 0, 0, 1);          // R3 wrap down
        run(5, 8'hFF, 0, 8'hFF, 1, 0);      // R4 FE01h
        run(5, 8'h0F, 0, 8'h11, 1, 0);      // R4 no overflow
        run(6, 8'hFB, 0, 8'h07, 1, 0);      // R5 divide
        run(6, 8'h33, 0, 8'h00, 0, 0);      // R5 divide by zero
        run(7, 8'h4C, 0, 0, 0, 0);          // R6 4Ch -> 52h
        run(7, 8'h9A, 0, 0, 0, 0);          // R6 both nibbles, carry out
        run(7, 8'h21, 0, 0, 1, 1);          // R6 flags force correction
        run(8, 8'hF0, 8'h3C, 0, 1, 1);      // R7
        run(11, 8'h5A, 0, 0, 0, 0);         // R7
        run(12, 8'h5A, 0, 0, 1, 0);         // R7
        run(13, 8'h81, 0, 0, 0, 0);         // R8
        run(16, 8'h01, 0, 0, 1, 0);         // R8
        run(15, 8'h3C, 0, 0, 1, 0);         // R8
        run(17, 8'h72, 0, 0, 0, 0);         // R9
        run(18, 8'hAB, 8'hCD, 0, 1, 1);     // R9
        run(25, 8'h44, 8'h55, 8'h66, 1, 1); // R10 unused code
        for (int i = 0; i < 3000; i++)
            run($urandom_range(0, 18), $urandom_range(0, 255), $urandom_range(0, 255),
                $urandom_range(0, 255), $urandom_range(0, 1), $urandom_range(0, 1));
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule